// File: doc/BRIEF.md
# Dual Saturating Fractional Multiply-Accumulate

This block multiplies two pairs of signed fractional operands and adds both products to an accumulator in a single clock. The result equals strict step-by-step evaluation: each product is clamped, the first product is added to the accumulator and clamped, and then the second product is added and clamped. A single-cycle datapath meets this by forming the sums in parallel. It forms the accumulator plus the first product, the three-operand sum, and a clamp bound plus the second product. It then keeps the candidate that the first addition's overflow calls for.

A mode input turns the unit into two independent saturating MACs, each with its own accumulator. Operands and accumulators are Q1.(DW-1) two's complement fractions. Products are truncated, not rounded. One flag reports whether any clamping step took place in the operation just completed.

Top module: `dual_sat_mac`

## Requirements
- R1: After reset, both accumulator outputs are zero and the saturation flag is low.
- R2: Each product is the Q1.(DW-1) fractional product truncated toward minus infinity, i.e. the signed full product shifted right by DW-1. When both operands are the most negative value (0x8000 for DW=16), the product clamps to the largest positive value (0x7FFF).
- R3: With en_i high and mode_i low (chained), acc1_o on the next clock equals clamp(clamp(acc1 + P1) + P2).
- R4: In chained mode, when acc1 + P1 overflows and P2 has the opposite sign, the result is computed from the clamped intermediate. For example, acc1=0x6FFF, P1=0x2000, P2=0xE000 gives 0x5FFF, not 0x6FFF.
- R5: In chained mode, when acc1 + P1 does not overflow but adding P2 does, the result clamps to the bound that matches the sign of the true sum.
- R6: With en_i high and mode_i high (split), acc1_o becomes clamp(acc1 + P1) and acc2_o becomes clamp(acc2 + P2) on the next clock.
- R7: In chained mode acc2_o is left unchanged.
- R8: While en_i is low, both accumulators hold their values and the saturation flag is low on the next clock.
- R9: sat_o is high in the cycle after an enabled operation if and only if that operation clamped a product or any of its additions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Perform an operation at this edge |
| mode_i | input | 1 | 0: chained into acc1, 1: two independent MACs |
| x1_i | input | DW | First multiplicand, pair 1 |
| y1_i | input | DW | Second multiplicand, pair 1 |
| x2_i | input | DW | First multiplicand, pair 2 |
| y2_i | input | DW | Second multiplicand, pair 2 |
| acc1_o | output | DW | Accumulator 1 |
| acc2_o | output | DW | Accumulator 2 |
| sat_o | output | 1 | A clamp occurred in the last operation |

## Verification
Every result comes out one clock after the edge that samples en_i. The accumulators and sat_o are registered directly from the combinational datapath, so there is no further pipeline stage. Each scenario task drives its operands on a falling edge and lets one rising edge pass. It compares the outputs at the next falling edge against a serial reference that clamps after every step. Hold and idle behaviour is checked with the same one-cycle offset.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SPLIT = 1'b1
  } mac_mode_e;

  localparam int unsigned GUARD_BITS = 2;
endpackage

// File: rtl/sat_frac_mul.sv
module sat_frac_mul #(
  parameter int unsigned DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] p_o,
  output logic                 sat_o
);
  localparam int unsigned PW = 2 * DW;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic signed [PW-1:0] full;
  logic                 unused_bits;

  assign full        = a_i * b_i;
  assign unused_bits = ^{full[PW-1], full[DW-2:0]};
  // only MIN*MIN leaves the fractional range
  assign sat_o       = (a_i == MINV) && (b_i == MINV);
  assign p_o         = sat_o ? MAXV : full[PW-2:DW-1];
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 18
) (
  input  logic signed [IW-1:0] v_i,
  output logic signed [DW-1:0] v_o,
  output logic                 sat_o
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic [IW-DW:0] top;

  assign top   = v_i[IW-1:DW-1];
  assign sat_o = !((&top) || !(|top));
  assign v_o   = !sat_o ? v_i[DW-1:0] : (v_i[IW-1] ? MINV : MAXV);
endmodule

// File: rtl/dual_sat_mac.sv
module dual_sat_mac
  import dmac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic [DW-1:0] x1_i,
  input  logic [DW-1:0] y1_i,
  input  logic [DW-1:0] x2_i,
  input  logic [DW-1:0] y2_i,
  output logic [DW-1:0] acc1_o,
  output logic [DW-1:0] acc2_o,
  output logic          sat_o
);
  localparam int unsigned SW = DW + GUARD_BITS;
  localparam int unsigned NMUL = 2;
  localparam int unsigned NCLP = 4;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  mac_mode_e mode;
  logic signed [DW-1:0] xa [NMUL];
  logic signed [DW-1:0] ya [NMUL];
  logic signed [DW-1:0] pa [NMUL];
  logic                 msat [NMUL];
  logic signed [SW-1:0] cin [NCLP];
  logic signed [DW-1:0] cout [NCLP];
  logic                 csat [NCLP];

  logic signed [DW-1:0] acc1_q, acc2_q;
  logic signed [SW-1:0] a1_w, a2_w, p1_w, p2_w, s1_w, v_w;
  logic signed [DW-1:0] acc1_d, acc2_d;
  logic                 sat_d;

  assign mode  = mac_mode_e'(mode_i);
  assign xa[0] = x1_i;
  assign ya[0] = y1_i;
  assign xa[1] = x2_i;
  assign ya[1] = y2_i;

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    sat_frac_mul #(.DW(DW)) u_mul (
      .a_i(xa[g]), .b_i(ya[g]), .p_o(pa[g]), .sat_o(msat[g])
    );
  end

  assign a1_w = {{GUARD_BITS{acc1_q[DW-1]}}, acc1_q};
  assign a2_w = {{GUARD_BITS{acc2_q[DW-1]}}, acc2_q};
  assign p1_w = {{GUARD_BITS{pa[0][DW-1]}}, pa[0]};
  assign p2_w = {{GUARD_BITS{pa[1][DW-1]}}, pa[1]};
  assign s1_w = a1_w + p1_w;
  // bound the first sum would clamp to, taken from its true sign
  assign v_w  = s1_w[SW-1] ? {{GUARD_BITS{1'b1}}, MINV} : {{GUARD_BITS{1'b0}}, MAXV};

  // 0: A+P1  1: A+P1+P2  2: V+P2  3: A2+P2
  assign cin[0] = s1_w;
  assign cin[1] = s1_w + p2_w;
  assign cin[2] = v_w + p2_w;
  assign cin[3] = a2_w + p2_w;

  for (genvar g = 0; g < NCLP; g++) begin : g_clp
    sat_clamp #(.DW(DW), .IW(SW)) u_clp (
      .v_i(cin[g]), .v_o(cout[g]), .sat_o(csat[g])
    );
  end

  always_comb begin
    acc1_d = acc1_q;
    acc2_d = acc2_q;
    sat_d  = 1'b0;
    if (en_i) begin
      if (mode == MODE_SPLIT) begin
        acc1_d = cout[0];
        acc2_d = cout[3];
        sat_d  = msat[0] | msat[1] | csat[0] | csat[3];
      end else begin
        acc1_d = csat[0] ? cout[2] : cout[1];
        sat_d  = msat[0] | msat[1] | csat[0] | (csat[0] ? csat[2] : csat[1]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc1_q <= '0;
      acc2_q <= '0;
      sat_o  <= 1'b0;
    end else begin
      acc1_q <= acc1_d;
      acc2_q <= acc2_d;
      sat_o  <= sat_d;
    end
  end

  assign acc1_o = acc1_q;
  assign acc2_o = acc2_q;
endmodule

// File: rtl/dual_sat_mac_chk.sv
module dual_sat_mac_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          mode_i,
  input logic [DW-1:0] x1_i,
  input logic [DW-1:0] y1_i,
  input logic [DW-1:0] x2_i,
  input logic [DW-1:0] y2_i,
  input logic [DW-1:0] acc1_o,
  input logic [DW-1:0] acc2_o,
  input logic          sat_o
);
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc1_o) && $stable(acc2_o) && !sat_o);

  a_r7_acc2_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !mode_i |=> $stable(acc2_o));

  a_r2_minmin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i && x1_i == MINV && y1_i == MINV && !acc1_o[DW-1]
    |=> acc1_o == MAXV && sat_o);

  a_r3_zero_prod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !mode_i && x1_i == '0 && x2_i == '0 |=> $stable(acc1_o) && !sat_o);

  a_r9_split_minmin2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i && x2_i == MINV && y2_i == MINV |=> sat_o);
endmodule

bind dual_sat_mac dual_sat_mac_chk #(.DW(DW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .x1_i(x1_i), .y1_i(y1_i), .x2_i(x2_i), .y2_i(y2_i),
  .acc1_o(acc1_o), .acc2_o(acc2_o), .sat_o(sat_o)
);

// File: tb/dual_sat_mac_tb_top.sv
`timescale 1ns/1ps
module dual_sat_mac_tb_top;
  localparam int unsigned DW = 16;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic mode_i = 1'b0;
  logic [DW-1:0] x1_i = '0, y1_i = '0, x2_i = '0, y2_i = '0;
  logic [DW-1:0] acc1_o, acc2_o;
  logic sat_o;

  int checks = 0;
  int failures = 0;
  longint m_acc1 = 0, m_acc2 = 0;
  logic   m_sat = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_sat_mac #(.DW(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .x1_i(x1_i), .y1_i(y1_i), .x2_i(x2_i), .y2_i(y2_i),
    .acc1_o(acc1_o), .acc2_o(acc2_o), .sat_o(sat_o)
  );

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint clampv(input longint v, output logic s);
    s = (v > MAXV) || (v < MINV);
    return (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
  endfunction

  function automatic longint fmul(input longint a, input longint b, output logic s);
    s = (a == MINV) && (b == MINV);
    return s ? MAXV : ((a * b) >>> (DW-1));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial reference: clamp after each step, in order
  task automatic model(input logic md, input longint x1, input longint y1,
                       input longint x2, input longint y2);
    logic s_m1, s_m2, s_a, s_b;
    longint p1, p2, t;
    p1 = fmul(x1, y1, s_m1);
    p2 = fmul(x2, y2, s_m2);
    if (md) begin
      m_acc1 = clampv(m_acc1 + p1, s_a);
      m_acc2 = clampv(m_acc2 + p2, s_b);
    end else begin
      t      = clampv(m_acc1 + p1, s_a);
      m_acc1 = clampv(t + p2, s_b);
    end
    m_sat = s_m1 | s_m2 | s_a | s_b;
  endtask

  task automatic op(input logic md, input logic [DW-1:0] x1, input logic [DW-1:0] y1,
                    input logic [DW-1:0] x2, input logic [DW-1:0] y2, input string req);
    @(negedge clk_i);
    en_i = 1'b1; mode_i = md; x1_i = x1; y1_i = y1; x2_i = x2; y2_i = y2;
    model(md, sx(x1), sx(y1), sx(x2), sy2(y2));
    @(posedge clk_i);
    @(negedge clk_i);
    en_i = 1'b0;
    check(req, sx(acc1_o), m_acc1);
    check(req, sx(acc2_o), m_acc2);
    check(req, longint'(sat_o), longint'(m_sat));
  endtask

  function automatic longint sy2(input logic [DW-1:0] v);
    return sx(v);
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0;
    m_acc1 = 0; m_acc2 = 0; m_sat = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", sx(acc1_o), 0);
    check("R1", sx(acc2_o), 0);
    check("R1", longint'(sat_o), 0);
  endtask

  task automatic t_split();
    do_reset();
    op(1'b1, 16'h4000, 16'h4000, 16'hC000, 16'h4000, "R6");
    check("R6", sx(acc1_o), 'sh2000);
    check("R6", sx(acc2_o), -'sh2000);
    op(1'b1, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R6");
  endtask

  task automatic t_minmin();
    do_reset();
    op(1'b1, 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, "R2");
    check("R2", sx(acc1_o), MAXV);
    check("R2", sx(acc2_o), -'sh7FFF);
    check("R9", longint'(sat_o), 1);
  endtask

  task automatic t_chain_basic();
    do_reset();
    op(1'b0, 16'h7FFF, 16'h7000, 16'h0000, 16'h0000, "R3");
    check("R3", sx(acc1_o), 'sh6FFF);
    check("R9", longint'(sat_o), 0);
    op(1'b0, 16'hE000, 16'h4000, 16'h1000, 16'h4000, "R3");
    check("R7", sx(acc2_o), 0);
  endtask

  task automatic t_first_sat_pos();
    do_reset();
    op(1'b0, 16'h7FFF, 16'h7000, 16'h0000, 16'h0000, "R4");
    op(1'b0, 16'h4000, 16'h4000, 16'hC000, 16'h4000, "R4");
    check("R4", sx(acc1_o), 'sh5FFF);
    check("R9", longint'(sat_o), 1);
  endtask

  task automatic t_first_sat_neg();
    do_reset();
    op(1'b0, 16'h8000, 16'h7000, 16'h0000, 16'h0000, "R4");
    check("R4", sx(acc1_o), -'sh7000);
    op(1'b0, 16'hC000, 16'h4000, 16'h4000, 16'h4000, "R4");
    check("R4", sx(acc1_o), -'sh6000);
  endtask

  task automatic t_second_sat();
    do_reset();
    op(1'b0, 16'h7FFF, 16'h7000, 16'h0000, 16'h0000, "R5");
    op(1'b0, 16'hE000, 16'h4000, 16'h7FFF, 16'h7FFF, "R5");
    check("R5", sx(acc1_o), MAXV);
    check("R9", longint'(sat_o), 1);
    op(1'b1, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, "R6");
    op(1'b1, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, "R6");
    op(1'b0, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, "R5");
    check("R5", sx(acc1_o), MINV);
  endtask

  task automatic t_hold();
    longint a1, a2;
    do_reset();
    op(1'b1, 16'h8000, 16'h8000, 16'h3000, 16'h5000, "R8");
    a1 = sx(acc1_o); a2 = sx(acc2_o);
    @(negedge clk_i);
    en_i = 1'b0; mode_i = 1'b1;
    x1_i = 16'h8000; y1_i = 16'h8000; x2_i = 16'h7FFF; y2_i = 16'h7FFF;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R8", sx(acc1_o), a1);
    check("R8", sx(acc2_o), a2);
    check("R8", longint'(sat_o), 0);
  endtask

  task automatic t_mixed();
    logic [31:0] lcg = 32'h1234_5678;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      logic [DW-1:0] v [4];
      for (int k = 0; k < 4; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        v[k] = lcg[31:16];
      end
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      op(lcg[20], v[0], v[1], v[2], v[3], lcg[20] ? "R6" : "R3");
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_split();
    t_minmin();
    t_chain_basic();
    t_first_sat_pos();
    t_first_sat_neg();
    t_second_sat();
    t_hold();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule